// File: doc/BRIEF.md
# Address-Routed Call/Return Stack Engine

This block carries out the stack side of a small processor core. Two independent 20-bit stack pointers, A and B, feed push, pop, call and return operations. The value in the selected pointer decides where each stacked word goes:

- When the pointer lies in the window 0x200 to 0x3FF, the word goes to a 512-word local RAM, and the pointer moves by one.
- Anywhere else, the word goes to a word-wide main-memory port that uses a request/acknowledge handshake, and the pointer moves by four.

The local path has fixed, short timing. The main path waits for as long as the memory takes to answer.

Plain loads and stores pass through the same engine but always use the main-memory port, whatever their address. A call stacks its return address and announces the jump target on a redirect output. A return unstacks an address and announces it on the same redirect output. Only one operation is in flight at a time, and `op_ready` low holds off any new request.

Top module: `stk_route_engine`

## Requirements
- R1: An operation of kind push (0), pop (1), call (2) or return (3) uses the local RAM when the selected pointer has bits 19..9 equal to 1 (values 0x200 to 0x3FF), at RAM index pointer[8:0]. Any other pointer value sends it to main memory with `mem_size` = 2 (long).
- R2: A local stack operation moves the pointer by 1. A main-memory stack operation moves it by 4. The pointer is updated on the accepting clock edge.
- R3: A local push or call takes two cycles: `op_ready` is low for exactly the one cycle after acceptance.
- R4: A local pop or return takes three cycles: `op_ready` is low for two cycles after acceptance, and the result appears in the second of them.
- R5: A push stores at the current pointer and then advances it. A pop first steps the pointer back and then reads from the new value. A sequence of pushes followed by pops therefore returns the data in reverse order.
- R6: A call stores `op_data[19:0]` zero-extended and presents `op_addr` on `redir_pc`. A return presents the low 20 bits of the unstacked word on `redir_pc`. Each redirect is a single-cycle `redir_valid` pulse, and a pop that follows a call returns the stored return address on `res_data`.
- R7: A load (4) or store (5) always goes to main memory at `op_addr` with `mem_size` = `op_size`, whatever the address. It leaves both pointers and the local RAM untouched. A load result appears on `res_data`.
- R8: A main-memory access keeps `mem_req`, `mem_addr` and `mem_wdata` steady until `mem_ack`, with `busy` high throughout. A local access never raises `busy` or `mem_req`.
- R9: Pointers A and B are independent. Only one operation is accepted per cycle, and `op_valid` is ignored while `op_ready` is low.
- R10: Both pointers reset to 0, and after reset `op_ready` is 1 while `busy`, `mem_req`, `res_valid` and `redir_valid` are 0. `ptr_ld` writes `ptr_ld_val` into the pointer that `ptr_ld_sel` selects, and takes precedence over a step of the same pointer in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_kind | input | 3 | 0 push, 1 pop, 2 call, 3 return, 4 load, 5 store |
| op_sel | input | 1 | Pointer select, 0 = A, 1 = B |
| op_addr | input | 20 | Call target, or load/store address |
| op_data | input | 32 | Push/store data; the low 20 bits are the return address for a call |
| op_size | input | 2 | Access size for a load/store |
| op_ready | output | 1 | Engine can accept an operation |
| busy | output | 1 | Waiting on main memory |
| ptr_ld | input | 1 | Pointer load strobe |
| ptr_ld_sel | input | 1 | Pointer to load |
| ptr_ld_val | input | 20 | Value to load |
| ptr_a | output | 20 | Pointer A |
| ptr_b | output | 20 | Pointer B |
| res_valid | output | 1 | Pop/load result strobe |
| res_data | output | 32 | Pop/load result |
| redir_valid | output | 1 | Program-counter redirect strobe |
| redir_pc | output | 20 | Redirect address |
| mem_req | output | 1 | Main-memory request |
| mem_we | output | 1 | Main-memory write |
| mem_size | output | 2 | Main-memory access size |
| mem_addr | output | 20 | Main-memory byte address |
| mem_wdata | output | 32 | Main-memory write data |
| mem_ack | input | 1 | Main-memory acknowledge |
| mem_rdata | input | 32 | Main-memory read data, valid with the acknowledge |

## Verification
The bench builds the engine with its default parameters: 20-bit pointers, 32-bit data and a 9-bit local index. With these, the whole 512-entry window can be filled and drained word by word, and every step can be checked against the fixed cycle counts.

The same setting puts both window edges within reach. The bench pushes from 0x1FF into main memory, which lands the pointer inside the window. It pushes from 0x3FF to 0x400, which carries the pointer out of the window. Main-memory answers come back after a three-cycle delay, which leaves room to drive requests against a held-off engine.

// File: rtl/stk_route_engine.sv
module stk_route_engine #(
  parameter int PTR_W  = 20,
  parameter int DATA_W = 32,
  parameter int LUT_AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_kind,
  input  logic              op_sel,
  input  logic [PTR_W-1:0]  op_addr,
  input  logic [DATA_W-1:0] op_data,
  input  logic [1:0]        op_size,
  output logic              op_ready,
  output logic              busy,
  input  logic              ptr_ld,
  input  logic              ptr_ld_sel,
  input  logic [PTR_W-1:0]  ptr_ld_val,
  output logic [PTR_W-1:0]  ptr_a,
  output logic [PTR_W-1:0]  ptr_b,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              redir_valid,
  output logic [PTR_W-1:0]  redir_pc,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int DEPTH = 1 << LUT_AW;
  localparam logic [2:0] K_PUSH = 3'd0, K_POP = 3'd1, K_CALL = 3'd2,
                         K_RET = 3'd3, K_LOAD = 3'd4, K_STORE = 3'd5;
  localparam logic [PTR_W-1:0] STEP_LOC = PTR_W'(1);
  localparam logic [PTR_W-1:0] STEP_MEM = PTR_W'(4);

  typedef enum logic [2:0] {S_IDLE, S_LWR, S_LRD1, S_LRD2, S_MEM} st_t;

  st_t               st;
  logic [2:0]        kind_q;
  logic [PTR_W-1:0]  addr_q, tgt_q;
  logic [DATA_W-1:0] wdata_q, rd_q;
  logic [1:0]        size_q;
  logic              we_q;
  logic [PTR_W-1:0]  pa_q, pb_q;
  logic [DATA_W-1:0] lram [DEPTH];

  wire [PTR_W-1:0] cur    = op_sel ? pb_q : pa_q;
  wire             in_win = cur[PTR_W-1:LUT_AW] == (PTR_W-LUT_AW)'(1);
  wire [PTR_W-1:0] step   = in_win ? STEP_LOC : STEP_MEM;
  wire             is_stk = op_kind <= K_RET;
  wire             is_put = (op_kind == K_PUSH) || (op_kind == K_CALL);
  wire [PTR_W-1:0] nxt    = is_put ? cur + step : cur - step;
  wire             accept = op_valid && op_ready;

  wire             m_done = (st == S_MEM) && mem_ack;
  wire             fin_rd = (st == S_LRD2) || (m_done && !we_q);
  wire [DATA_W-1:0] rdv   = (st == S_LRD2) ? rd_q : mem_rdata;

  assign op_ready    = st == S_IDLE;
  assign mem_req     = st == S_MEM;
  assign busy        = st == S_MEM;
  assign mem_we      = we_q;
  assign mem_addr    = addr_q;
  assign mem_wdata   = wdata_q;
  assign mem_size    = size_q;
  assign ptr_a       = pa_q;
  assign ptr_b       = pb_q;
  assign res_valid   = fin_rd && (kind_q != K_RET);
  assign res_data    = rdv;
  assign redir_valid = (kind_q == K_CALL && ((st == S_LWR) || (m_done && we_q))) ||
                       (kind_q == K_RET && fin_rd);
  assign redir_pc    = (kind_q == K_CALL) ? tgt_q : rdv[PTR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      kind_q  <= K_PUSH;
      addr_q  <= '0;
      tgt_q   <= '0;
      wdata_q <= '0;
      size_q  <= 2'd0;
      we_q    <= 1'b0;
      pa_q    <= '0;
      pb_q    <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          kind_q <= op_kind;
          if (is_stk) begin
            addr_q  <= is_put ? cur : nxt;
            wdata_q <= (op_kind == K_CALL) ? DATA_W'(op_data[PTR_W-1:0]) : op_data;
            tgt_q   <= op_addr;
            size_q  <= 2'd2;
            we_q    <= is_put;
            st      <= in_win ? (is_put ? S_LWR : S_LRD1) : S_MEM;
            if (op_sel) pb_q <= nxt;
            else        pa_q <= nxt;
          end else if (op_kind == K_LOAD || op_kind == K_STORE) begin
            addr_q  <= op_addr;
            wdata_q <= op_data;
            size_q  <= op_size;
            we_q    <= op_kind == K_STORE;
            st      <= S_MEM;
          end
        end
        S_LWR:   st <= S_IDLE;
        S_LRD1:  st <= S_LRD2;
        S_LRD2:  st <= S_IDLE;
        S_MEM:   if (mem_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (ptr_ld) begin
        if (ptr_ld_sel) pb_q <= ptr_ld_val;
        else            pa_q <= ptr_ld_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_LWR) lram[addr_q[LUT_AW-1:0]] <= wdata_q;
    if (st == S_LRD1) rd_q <= lram[addr_q[LUT_AW-1:0]];
  end
endmodule

module stk_route_engine_chk #(
  parameter int PTR_W  = 20,
  parameter int DATA_W = 32,
  parameter int LUT_AW = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [2:0]        op_kind,
  input logic              op_sel,
  input logic [PTR_W-1:0]  op_addr,
  input logic [DATA_W-1:0] op_data,
  input logic [1:0]        op_size,
  input logic              op_ready,
  input logic              busy,
  input logic              ptr_ld,
  input logic              ptr_ld_sel,
  input logic [PTR_W-1:0]  ptr_ld_val,
  input logic [PTR_W-1:0]  ptr_a,
  input logic [PTR_W-1:0]  ptr_b,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data,
  input logic              redir_valid,
  input logic [PTR_W-1:0]  redir_pc,
  input logic              mem_req,
  input logic              mem_we,
  input logic [1:0]        mem_size,
  input logic [PTR_W-1:0]  mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic [DATA_W-1:0] mem_rdata
);
  wire [PTR_W-1:0] sel_p = op_sel ? ptr_b : ptr_a;
  wire loc = sel_p[PTR_W-1:LUT_AW] == (PTR_W-LUT_AW)'(1);
  wire acc = op_valid && op_ready;

  a_r3_call_local_two: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_kind == 3'd2 && loc |=> !op_ready ##1 op_ready);

  a_r4_ret_local_three: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_kind == 3'd3 && loc |=> !op_ready ##1 !op_ready ##1 op_ready);

  a_r2_local_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !op_sel && op_kind == 3'd0 && loc && !ptr_ld |=> ptr_a == $past(ptr_a) + PTR_W'(1));

  a_r2_main_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_sel && op_kind == 3'd1 && !loc && !ptr_ld |=> ptr_b == $past(ptr_b) - PTR_W'(4));

  a_r7_load_to_main: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_kind == 3'd4 |=> mem_req && !mem_we && mem_addr == $past(op_addr));

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

  a_r8_local_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_kind <= 3'd3 && loc |=> !busy && !mem_req);

  a_r6_redir_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !redir_valid);

  a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc && !ptr_ld |=> $stable(ptr_a) && $stable(ptr_b));
endmodule

bind stk_route_engine stk_route_engine_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W), .LUT_AW(LUT_AW)) u_chk (.*);

// File: tb/test_stk_route_engine.sv
module test_stk_route_engine;
  localparam int CLK_P = 10;
  localparam int MLAT  = 3;
  localparam logic [2:0] PUSH = 0, POP = 1, CALL = 2, RET = 3, LOAD = 4, STORE = 5;

  logic clk = 0, rst_n = 0;
  logic op_valid = 0, op_sel = 0, ptr_ld = 0, ptr_ld_sel = 0, mem_ack = 0;
  logic [2:0] op_kind = 0;
  logic [19:0] op_addr = 0, ptr_ld_val = 0;
  logic [31:0] op_data = 0, mem_rdata = 0;
  logic [1:0] op_size = 0;
  logic op_ready, busy, res_valid, redir_valid, mem_req, mem_we;
  logic [19:0] ptr_a, ptr_b, redir_pc, mem_addr;
  logic [31:0] res_data, mem_wdata;
  logic [1:0] mem_size;

  stk_route_engine i_stk_route_engine (.*);

  always #(CLK_P/2) clk = ~clk;

  int nvec = 0, nbad = 0;
  int res_cnt, redir_cnt, busy_cnt, mtx;
  logic [31:0] res_last, l_wdata;
  logic [19:0] redir_last, l_addr;
  logic l_we;
  logic [1:0] l_size;
  logic [31:0] mm [logic [19:0]];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  initial begin
    res_cnt = 0; redir_cnt = 0; busy_cnt = 0;
    forever begin
      @(negedge clk);
      if (res_valid) begin res_cnt++; res_last = res_data; end
      if (redir_valid) begin redir_cnt++; redir_last = redir_pc; end
      if (busy || mem_req) busy_cnt++;
    end
  end

  initial begin
    int w;
    w = 0; mtx = 0;
    forever begin
      @(posedge clk); #1;
      if (mem_ack) begin
        mem_ack = 0; w = 0;
      end else if (mem_req) begin
        w++;
        if (w == MLAT) begin
          mem_ack = 1; mtx++;
          l_addr = mem_addr; l_we = mem_we; l_wdata = mem_wdata; l_size = mem_size;
          if (mem_we) mm[mem_addr] = mem_wdata;
          else mem_rdata = mm.exists(mem_addr) ? mm[mem_addr] : {12'hDEA, mem_addr};
        end
      end
    end
  end

  task automatic run_op(input logic [2:0] k, input logic s, input logic [19:0] a,
                        input logic [31:0] d, input logic [1:0] sz, output int cyc);
    @(negedge clk);
    res_cnt = 0; redir_cnt = 0; busy_cnt = 0;
    op_kind = k; op_sel = s; op_addr = a; op_data = d; op_size = sz; op_valid = 1;
    @(negedge clk);
    op_valid = 0; cyc = 1;
    while (!op_ready) begin @(negedge clk); cyc++; end
  endtask

  task automatic set_ptr(input logic s, input logic [19:0] v);
    @(negedge clk);
    ptr_ld = 1; ptr_ld_sel = s; ptr_ld_val = v;
    @(negedge clk);
    ptr_ld = 0;
  endtask

  initial begin
    #(CLK_P*200000);
    nbad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int c, m0;
    logic [19:0] pb;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset ready", op_ready, 1);
    chk("R10 reset busy", busy, 0);
    chk("R10 reset mem_req", mem_req, 0);
    chk("R10 reset ptr_a", ptr_a, 0);
    chk("R10 reset ptr_b", ptr_b, 0);
    chk("R10 reset strobes", {res_valid, redir_valid}, 0);

    // Fill the local window from 0x200 and drain it in reverse
    set_ptr(0, 20'h200);
    m0 = mtx;
    for (int i = 0; i < 511; i++) begin
      run_op(PUSH, 0, 0, pat(i), 0, c);
      chk("R3 local push cycles", c, 2);
      chk("R8 local push not busy", busy_cnt, 0);
    end
    chk("R1 local pushes stay off main", mtx, m0);
    chk("R2 local step", ptr_a, 20'h3FF);
    run_op(PUSH, 0, 0, pat(511), 0, c);
    chk("R2 top of window to 0x400", ptr_a, 20'h400);
    chk("R1 0x3FF local", mtx, m0);
    run_op(PUSH, 0, 0, 32'hCAFE0001, 0, c);
    chk("R1 0x400 main addr", l_addr, 20'h400);
    chk("R1 main size long", l_size, 2);
    chk("R1 main write", {l_we, l_wdata}, {1'b1, 32'hCAFE0001});
    chk("R2 main step", ptr_a, 20'h404);
    chk("R8 main busy seen", busy_cnt > 0, 1);
    run_op(POP, 0, 0, 0, 0, c);
    chk("R5 main pop data", res_last, 32'hCAFE0001);
    chk("R5 main pop addr", {l_we, l_addr}, {1'b0, 20'h400});
    chk("R2 main pop step", ptr_a, 20'h400);
    set_ptr(0, 20'h3FF);
    for (int j = 0; j < 511; j++) begin
      run_op(POP, 0, 0, 0, 0, c);
      chk("R4 local pop cycles", c, 3);
      chk("R5 LIFO data", res_last, pat(510 - j));
      chk("R4 single result", res_cnt, 1);
    end
    chk("R2 drained pointer", ptr_a, 20'h200);
    chk("R9 ptr_b untouched", ptr_b, 0);

    // Pointer B through main memory at 0
    run_op(PUSH, 1, 0, 32'h0B0B0B0B, 0, c);
    chk("R1 ptr_b 0 main", l_addr, 0);
    chk("R9 ptr_b step", ptr_b, 4);
    chk("R9 ptr_a unchanged", ptr_a, 20'h200);
    run_op(POP, 1, 0, 0, 0, c);
    chk("R5 ptr_b pop", res_last, 32'h0B0B0B0B);

    // Local call / return
    set_ptr(0, 20'h300);
    run_op(CALL, 0, 20'h12345, 32'hFFFABCDE, 0, c);
    chk("R3 local call cycles", c, 2);
    chk("R6 call redirect count", redir_cnt, 1);
    chk("R6 call target", redir_last, 20'h12345);
    chk("R2 call step", ptr_a, 20'h301);
    run_op(POP, 0, 0, 0, 0, c);
    chk("R6 pop after call", res_last, 32'h000ABCDE);
    chk("R6 pop no redirect", redir_cnt, 0);
    run_op(CALL, 0, 20'h00777, 32'h00054321, 0, c);
    run_op(RET, 0, 0, 0, 0, c);
    chk("R4 local ret cycles", c, 3);
    chk("R6 ret address", redir_last, 20'h54321);
    chk("R6 ret one pulse", redir_cnt, 1);
    chk("R6 ret no result", res_cnt, 0);
    chk("R2 ret step", ptr_a, 20'h300);

    // Main call / return on B
    set_ptr(1, 20'h01000);
    run_op(CALL, 1, 20'h0ABCD, 32'h00011111, 0, c);
    chk("R6 main call write", {l_addr, l_wdata}, {20'h01000, 32'h00011111});
    chk("R6 main call target", redir_last, 20'h0ABCD);
    chk("R2 main call step", ptr_b, 20'h01004);
    run_op(RET, 1, 0, 0, 0, c);
    chk("R6 main ret address", redir_last, 20'h11111);
    chk("R6 main ret pulses", redir_cnt, 1);
    chk("R2 main ret step", ptr_b, 20'h01000);

    // Load/store always main, even inside the window
    set_ptr(0, 20'h3F0);
    run_op(PUSH, 0, 0, 32'h600DF00D, 0, c);
    m0 = mtx;
    run_op(STORE, 0, 20'h3F0, 32'hBAD0BAD0, 1, c);
    chk("R7 store to main", mtx, m0 + 1);
    chk("R7 store fields", {l_we, l_size, l_addr}, {1'b1, 2'd1, 20'h3F0});
    chk("R7 store keeps pointer", ptr_a, 20'h3F1);
    run_op(LOAD, 0, 20'h3F0, 0, 0, c);
    chk("R7 load data", res_last, 32'hBAD0BAD0);
    chk("R7 load fields", {l_we, l_size}, {1'b0, 2'd0});
    run_op(POP, 0, 0, 0, 0, c);
    chk("R7 local RAM untouched", res_last, 32'h600DF00D);

    // Window lower edge
    set_ptr(0, 20'h1FF);
    m0 = mtx;
    run_op(PUSH, 0, 0, 32'h77, 0, c);
    chk("R1 0x1FF main", {mtx == m0 + 1, l_addr}, {1'b1, 20'h1FF});
    chk("R2 0x1FF main step", ptr_a, 20'h203);

    // Local op on B leaves A alone
    set_ptr(1, 20'h210);
    run_op(PUSH, 1, 0, 32'h1, 0, c);
    chk("R9 local B step", ptr_b, 20'h211);
    chk("R9 A stays", ptr_a, 20'h203);

    // Requests while not ready are ignored
    set_ptr(0, 20'h2000);
    pb = ptr_b;
    m0 = mtx;
    @(negedge clk);
    op_kind = PUSH; op_sel = 0; op_data = 32'h11; op_valid = 1;
    @(negedge clk);
    op_sel = 1; op_data = 32'h22;
    @(negedge clk);
    op_valid = 0;
    while (!op_ready) @(negedge clk);
    @(negedge clk);
    chk("R9 held-off ptr_b", ptr_b, pb);
    chk("R9 one transaction", mtx, m0 + 1);
    chk("R9 accepted write", l_wdata, 32'h11);

    // Pointer load beats a step
    set_ptr(0, 20'h200);
    @(negedge clk);
    op_kind = PUSH; op_sel = 0; op_data = 32'h5; op_valid = 1;
    ptr_ld = 1; ptr_ld_sel = 0; ptr_ld_val = 20'h280;
    @(negedge clk);
    op_valid = 0; ptr_ld = 0;
    while (!op_ready) @(negedge clk);
    chk("R10 load overrides step", ptr_a, 20'h280);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule